// File: doc/BRIEF.md
# Latched Interrupt Cause and Mask Unit

This block gathers single-cycle event pulses from a multi-channel time-division voice port into one cause register and drives a single level interrupt. Each channel reports four events: transmit buffer done, receive buffer done, transmit underflow and receive overflow. Two global events are added to these: a line interrupt from the codec and an abort from the DMA engine.

Two masks control the block. The latch mask decides which events may set their cause bit at all. The enable mask decides which set cause bits drive the interrupt. Software reads the cause register without side effects. It acknowledges events by writing the cause address with zeros in the bit positions it wants cleared and ones everywhere else. An event that arrives in the same cycle as a clearing write is not lost.

A simple register strobe gives access to the block. A write strobe, a 2-bit address and write data are sampled on the clock. Read data is a combinational function of the address.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause register, the latch mask and the enable mask all read zero, and irq_o is 0.
- R2: An event pulse whose latch-mask bit is 1 sets its cause bit at the next clock edge, and the bit stays set until it is cleared.
- R3: An event pulse whose latch-mask bit is 0 never sets its cause bit.
- R4: A write to address 0 clears each cause bit where the written data bit is 0 and keeps each bit where it is 1. Writing a 1 never sets a cause bit.
- R5: With no events and no write to address 0, the cause register holds its value. Reads and writes to other addresses do not change it.
- R6: An event that is latched in the same cycle as a clearing write to address 0 leaves its cause bit set.
- R7: irq_o is 1 exactly when some cause bit and the matching enable-mask bit are both 1.
- R8: Cause bit positions, with c the channel number and N the channel count (default 2):
  - bit 0: codec line
  - bit 1: DMA abort
  - bit 2+c: transmit done
  - bit 2+N+c: receive done
  - bit 2+2N+c: transmit underflow
  - bit 2+3N+c: receive overflow
- R9: The latch mask (address 1) and the enable mask (address 2) store and read back all 18 written bits. Cause bits above 2+4N-1 are reserved and always read 0.
- R10: The register map is: address 0 cause, address 1 latch mask, address 2 enable mask. Address 3 reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| codec_evt_i | input | 1 | Codec line event pulse |
| dma_abort_evt_i | input | 1 | DMA abort event pulse |
| tx_done_i | input | NUM_CH | Per-channel transmit buffer done pulse |
| rx_done_i | input | NUM_CH | Per-channel receive buffer done pulse |
| tx_underflow_i | input | NUM_CH | Per-channel transmit underflow pulse |
| rx_overflow_i | input | NUM_CH | Per-channel receive overflow pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CAUSE_W | Write data |
| reg_rdata_o | output | CAUSE_W | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt, level |

## Verification
The assertions assume that the event inputs and the register strobe are stable around the clock edge. They also assume that reset is applied before the first checked edge, so every comparison with the previous cycle refers to a cycle after reset. The stimulus changes every input only on the falling clock edge and releases reset on a falling edge. Random phases mix events with clearing writes, mask writes and idle cycles, so that events coincide with clears and masks change while events are in flight.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  typedef enum logic [1:0] {
    SEL_CAUSE  = 2'd0,
    SEL_LATCH  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned GLOBAL_EVTS = 2;
  localparam int unsigned EVTS_PER_CH = 4;
endpackage

// File: rtl/irq_evt_map.sv
module irq_evt_map #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CAUSE_W = 18
) (
  input  logic              codec_evt_i,
  input  logic              dma_abort_evt_i,
  input  logic [NUM_CH-1:0] tx_done_i,
  input  logic [NUM_CH-1:0] rx_done_i,
  input  logic [NUM_CH-1:0] tx_underflow_i,
  input  logic [NUM_CH-1:0] rx_overflow_i,
  output logic [CAUSE_W-1:0] evt_vec_o
);
  import irq_cause_pkg::*;

  localparam int unsigned TXD_OFS = GLOBAL_EVTS;
  localparam int unsigned RXD_OFS = TXD_OFS + NUM_CH;
  localparam int unsigned TXU_OFS = RXD_OFS + NUM_CH;
  localparam int unsigned RXO_OFS = TXU_OFS + NUM_CH;
  localparam int unsigned USED_W  = RXO_OFS + NUM_CH;

  assign evt_vec_o[0] = codec_evt_i;
  assign evt_vec_o[1] = dma_abort_evt_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign evt_vec_o[TXD_OFS+c] = tx_done_i[c];
    assign evt_vec_o[RXD_OFS+c] = rx_done_i[c];
    assign evt_vec_o[TXU_OFS+c] = tx_underflow_i[c];
    assign evt_vec_o[RXO_OFS+c] = rx_overflow_i[c];
  end

  if (USED_W < CAUSE_W) begin : g_rsvd
    assign evt_vec_o[CAUSE_W-1:USED_W] = '0;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned          W   = 18,
  parameter logic [W-1:0]         RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (wr_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned W      = 18,
  parameter int unsigned USED_W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] latch_mask_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LIVE = W'((64'd1 << USED_W) - 64'd1);

  logic [W-1:0] keep, set_bits, d;

  // zero in write data clears; new event wins over the clear
  assign keep     = clr_wr_i ? wdata_i : '1;
  assign set_bits = evt_i & latch_mask_i;
  assign d        = ((q_o & keep) | set_bits) & LIVE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CAUSE_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               codec_evt_i,
  input  logic               dma_abort_evt_i,
  input  logic [NUM_CH-1:0]  tx_done_i,
  input  logic [NUM_CH-1:0]  rx_done_i,
  input  logic [NUM_CH-1:0]  tx_underflow_i,
  input  logic [NUM_CH-1:0]  rx_overflow_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [CAUSE_W-1:0] reg_wdata_i,
  output logic [CAUSE_W-1:0] reg_rdata_o,
  output logic               irq_o
);
  import irq_cause_pkg::*;

  localparam int unsigned USED_W = GLOBAL_EVTS + EVTS_PER_CH * NUM_CH;

  reg_sel_e           sel;
  logic               cause_wr, latch_wr, enable_wr;
  logic [CAUSE_W-1:0] evt_vec, cause_q, latch_mask_q, en_mask_q;

  assign sel       = reg_sel_e'(reg_addr_i);
  assign cause_wr  = reg_wr_i && (sel == SEL_CAUSE);
  assign latch_wr  = reg_wr_i && (sel == SEL_LATCH);
  assign enable_wr = reg_wr_i && (sel == SEL_ENABLE);

  irq_evt_map #(.NUM_CH(NUM_CH), .CAUSE_W(CAUSE_W)) u_map (
    .codec_evt_i     (codec_evt_i),
    .dma_abort_evt_i (dma_abort_evt_i),
    .tx_done_i       (tx_done_i),
    .rx_done_i       (rx_done_i),
    .tx_underflow_i  (tx_underflow_i),
    .rx_overflow_i   (rx_overflow_i),
    .evt_vec_o       (evt_vec)
  );

  irq_mask_reg #(.W(CAUSE_W), .RST('0)) u_latch_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (latch_wr),
    .wdata_i (reg_wdata_i),
    .q_o     (latch_mask_q)
  );

  irq_mask_reg #(.W(CAUSE_W), .RST('0)) u_en_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (enable_wr),
    .wdata_i (reg_wdata_i),
    .q_o     (en_mask_q)
  );

  irq_cause_reg #(.W(CAUSE_W), .USED_W(USED_W)) u_cause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_vec),
    .latch_mask_i (latch_mask_q),
    .clr_wr_i     (cause_wr),
    .wdata_i      (reg_wdata_i),
    .q_o          (cause_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CAUSE:  reg_rdata_o = cause_q;
      SEL_LATCH:  reg_rdata_o = latch_mask_q;
      SEL_ENABLE: reg_rdata_o = en_mask_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(cause_q & en_mask_q);
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CAUSE_W = 18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CAUSE_W-1:0] evt_vec,
  input logic [CAUSE_W-1:0] latch_mask,
  input logic [CAUSE_W-1:0] en_mask,
  input logic [CAUSE_W-1:0] cause,
  input logic               cause_wr,
  input logic [CAUSE_W-1:0] wdata,
  input logic               irq_o
);
  localparam int unsigned USED_W = 2 + 4 * NUM_CH;

  assert_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause & $past(evt_vec & latch_mask)) == $past(evt_vec & latch_mask)));

  assert_no_spurious_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(evt_vec & latch_mask)) == '0));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_wr |=> ((cause & ~$past(wdata) & ~$past(evt_vec & latch_mask)) == '0));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cause_wr && ((evt_vec & latch_mask) == '0)) |=> $stable(cause));

  assert_quiet_no_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause == '0) |-> !irq_o);

  assert_quiet_no_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mask == '0) |-> !irq_o);

  if (USED_W < CAUSE_W) begin : g_rsvd
    assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause[CAUSE_W-1:USED_W] == '0);
  end
endmodule

bind irq_cause_unit irq_cause_chk #(.NUM_CH(NUM_CH), .CAUSE_W(CAUSE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_vec    (evt_vec),
  .latch_mask (latch_mask_q),
  .en_mask    (en_mask_q),
  .cause      (cause_q),
  .cause_wr   (cause_wr),
  .wdata      (reg_wdata_i),
  .irq_o      (irq_o)
);

// File: tb/sim_irq_cause_unit.sv
module sim_irq_cause_unit;
  localparam int NCH = 2;
  localparam int W   = 18;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic codec = 1'b0, dma = 1'b0;
  logic [NCH-1:0] txd = '0, rxd = '0, txu = '0, rxo = '0;
  logic wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq;

  int errors = 0, checks = 0;
  logic [W-1:0] m_cause = '0, m_latch = '0, m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_unit #(.NUM_CH(NCH), .CAUSE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .codec_evt_i(codec), .dma_abort_evt_i(dma),
    .tx_done_i(txd), .rx_done_i(rxd), .tx_underflow_i(txu), .rx_overflow_i(rxo),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [W-1:0] pack_evts();
    logic [W-1:0] v = '0;
    v[0] = codec;
    v[1] = dma;
    for (int c = 0; c < NCH; c++) begin
      v[2 + c]         = txd[c];
      v[2 + NCH + c]   = rxd[c];
      v[2 + 2*NCH + c] = txu[c];
      v[2 + 3*NCH + c] = rxo[c];
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_read();
    case (addr)
      2'd0: return m_cause;
      2'd1: return m_latch;
      2'd2: return m_en;
      default: return '0;
    endcase
  endfunction

  task automatic compare_all();
    string tag;
    case (addr)
      2'd0: tag = "R2";
      2'd3: tag = "R10";
      default: tag = "R9";
    endcase
    chk(tag, rdata, model_read());
    chk("R7", W'(irq), W'(|(m_cause & m_en)));
  endtask

  // one clock: model update at the edge, compare at the falling edge, then drop pulses
  task automatic tick();
    logic [W-1:0] nc;
    @(posedge clk);
    nc = m_cause;
    if (wr && addr == 2'd0) nc = nc & wdata;
    nc = (nc | (pack_evts() & m_latch)) & W'((1 << (2 + 4*NCH)) - 1);
    if (wr && addr == 2'd1) m_latch = wdata;
    if (wr && addr == 2'd2) m_en = wdata;
    m_cause = nc;
    @(negedge clk);
    compare_all();
    codec = 0; dma = 0; txd = '0; rxd = '0; txu = '0; rxo = '0; wr = 0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [W-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      addr = 2'(a);
      #1 chk("R1", rdata, '0);
    end
    chk("R1", W'(irq), '0);

    reg_write(2'd1, 18'h3ffff);
    addr = 2'd1; #1 chk("R9", rdata, 18'h3ffff);

    // R8 bit positions
    addr = 0; codec = 1;    tick(); chk("R8", rdata, 18'h001); reg_write(0, 0); chk("R4", rdata, 0);
    addr = 0; dma = 1;      tick(); chk("R8", rdata, 18'h002); reg_write(0, 0);
    addr = 0; txd = 2'b10;  tick(); chk("R8", rdata, 18'h008); reg_write(0, 0);
    addr = 0; rxd = 2'b01;  tick(); chk("R8", rdata, 18'h010); reg_write(0, 0);
    addr = 0; txu = 2'b10;  tick(); chk("R8", rdata, 18'h080); reg_write(0, 0);
    addr = 0; rxo = 2'b01;  tick(); chk("R8", rdata, 18'h100); reg_write(0, 0);

    // R4 selective clear, ones do not set
    addr = 0; codec = 1; dma = 1; txd = '1; rxd = '1; txu = '1; rxo = '1;
    tick(); chk("R2", rdata, 18'h3ff);
    reg_write(0, 18'h0f0); chk("R4", rdata, 18'h0f0);
    reg_write(0, 18'h3ffff); chk("R4", rdata, 18'h0f0);
    chk("R9", rdata & 18'h3fc00, 0);

    // R5 hold across idle and other-address accesses
    addr = 1; repeat (5) tick();
    reg_write(2'd2, 0);
    reg_write(2'd3, 18'h3ffff);
    addr = 0; #1 chk("R5", rdata, 18'h0f0);
    addr = 3; #1 chk("R10", rdata, 0);

    // R6 event during clear
    addr = 0; codec = 1; wdata = 0; wr = 1; tick(); chk("R6", rdata, 18'h001);

    // R7 interrupt gating
    chk("R7", W'(irq), 0);
    reg_write(2'd2, 18'h001); chk("R7", W'(irq), 1);
    reg_write(2'd2, 18'h002); chk("R7", W'(irq), 0);
    reg_write(2'd2, 18'h001);
    reg_write(2'd0, 18'h0); chk("R7", W'(irq), 0);

    // R3 masked event
    reg_write(2'd1, 18'h3fffe);
    addr = 0; codec = 1; tick(); chk("R3", rdata, 0);
    addr = 0; dma = 1;   tick(); chk("R2", rdata, 18'h002);

    // random phase, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      codec = 1'($urandom); dma = 1'($urandom);
      txd = NCH'($urandom); rxd = NCH'($urandom);
      txu = NCH'($urandom); rxo = NCH'($urandom);
      addr = 2'($urandom);
      wdata = W'($urandom);
      wr = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) begin codec = 0; dma = 0; txd = '0; rxd = '0; txu = '0; rxo = '0; end
      tick();
    end
    finish_run();
  end
endmodule